// File: doc/BRIEF.md
# Jitter Buffer Address Controller

This block generates the write and read byte addresses for a de-interleave buffer that sits in an external RAM of 2K bytes. Incoming frames set the pace of writes, and the local output clock sets the pace of reads. Each address is a frame index joined to a byte offset within that frame. The block also keeps a signed count of how far the write frame position has moved away from its nominal spacing to the read frame position. This count is the buffer fill.

The fill is fed back to a disc motor constant-linear-velocity servo as two hints. One asks the motor to speed up and the other asks it to slow down. The fill is also published as a 3-bit status code. If the fill moves past ±5 frames, the block flags an overflow for one cycle and puts the read pointer back to a fill of −1. It also mutes the output until the next output frame has gone by. After that, address generation carries on with no outside help.

Top module: `jitbuf_addr_ctl`

## Requirements
- R1: After reset the fill is 0, the status code is 000, speed_up, slow_down, buf_over and mute are low, wr_addr is 0 and rd_addr is 1024, which is frame index 32 and offset 0.
- R2: On the edge after a strobe, the fill rises by one for a write frame strobe and falls by one for a read frame strobe. If both strobes arrive in the same cycle, the fill does not change.
- R3: fill_code gives the fill as a 3-bit two's-complement number, clamped to the range −3..+3. For example, −1 is 111 and −3 is 101. While buf_over is high, fill_code is 100.
- R4: speed_up is high when the fill is −2 or lower. slow_down is high when the fill is +2 or higher. Both are low for fills from −1 to +1, and both are low while buf_over is high.
- R5: If a strobe would take the fill to +6 or −6, buf_over is high for exactly one cycle. On the next cycle the fill is −1.
- R6: mute rises together with buf_over. It stays high until the first read frame strobe that arrives while buf_over is low. Write strobes do not clear it.
- R7: Each address is frame_index×32 + byte_offset, with a 6-bit frame index and a 5-bit offset. A byte strobe adds one to the offset and wraps at 32. A frame strobe adds one to the index (mod 64) and clears the offset. A frame strobe wins over a byte strobe in the same cycle.
- R8: At overflow recovery, the read frame index becomes the write frame index minus 31 (mod 64) and the read offset becomes 0. From then on, the write-to-read frame spacing is always 32 plus the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_frame | input | 1 | Incoming frame boundary strobe |
| wr_byte | input | 1 | Incoming byte strobe |
| rd_frame | input | 1 | Output frame boundary strobe |
| rd_byte | input | 1 | Output byte strobe |
| wr_addr | output | 11 | RAM write address |
| rd_addr | output | 11 | RAM read address |
| speed_up | output | 1 | Fill is low; motor should speed up |
| slow_down | output | 1 | Fill is high; motor should slow down |
| buf_over | output | 1 | One-cycle overflow flag |
| mute | output | 1 | Output mute request |
| fill_code | output | 3 | Clamped fill status code |

## Verification
Every output comes from a register that is updated at the edge where a strobe is seen. As a result, each address, hint, status code and mute change is due exactly one edge after its strobe. The recovered fill and the repositioned read pointer are due one edge after buf_over rises. The bench drives every strobe at a falling edge and removes it at the next falling edge. It samples all outputs at that same falling edge, which falls half a period after the edge that should have taken effect. This means a result that arrives one cycle early or one cycle late is read as wrong.

// File: rtl/jitbuf_addr_ctl.sv
module jitbuf_addr_ctl #(
  parameter int ADDR_W     = 11,
  parameter int FRAME_BITS = 5,
  parameter int FILL_W     = 4,
  parameter int LIMIT      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_frame,
  input  logic              wr_byte,
  input  logic              rd_frame,
  input  logic              rd_byte,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              speed_up,
  output logic              slow_down,
  output logic              buf_over,
  output logic              mute,
  output logic [2:0]        fill_code
);
  localparam int POS_W  = ADDR_W - FRAME_BITS;
  localparam int FRAMES = 1 << POS_W;
  localparam int HALF   = FRAMES / 2;
  localparam logic [POS_W-1:0] HALF_P   = POS_W'(HALF);
  localparam logic [POS_W-1:0] REWIND_P = POS_W'(HALF - 1);
  localparam logic signed [FILL_W:0] LIM_HI = (FILL_W+1)'(LIMIT);
  localparam logic signed [FILL_W:0] LIM_LO = -(FILL_W+1)'(LIMIT);
  localparam logic signed [FILL_W-1:0] CODE_HI = FILL_W'(3);
  localparam logic signed [FILL_W-1:0] CODE_LO = -FILL_W'(3);
  localparam logic signed [FILL_W-1:0] HINT_HI = FILL_W'(2);
  localparam logic signed [FILL_W-1:0] HINT_LO = -FILL_W'(2);

  logic [POS_W-1:0]      wr_pos, rd_pos, wr_pos_n;
  logic [FRAME_BITS-1:0] wr_off, rd_off;
  logic signed [FILL_W-1:0] fill, fill_sat;
  logic signed [FILL_W:0]   fill_step;
  logic ovf, ovf_hit, mute_q;

  assign wr_pos_n = wr_frame ? wr_pos + 1'b1 : wr_pos;

  always_comb begin
    fill_step = {fill[FILL_W-1], fill};
    if (wr_frame && !rd_frame)      fill_step = fill_step + (FILL_W+1)'(1);
    else if (rd_frame && !wr_frame) fill_step = fill_step - (FILL_W+1)'(1);
  end

  assign ovf_hit = (fill_step > LIM_HI) || (fill_step < LIM_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_pos <= '0;
      wr_off <= '0;
      rd_pos <= HALF_P;
      rd_off <= '0;
      fill   <= '0;
      ovf    <= 1'b0;
      mute_q <= 1'b0;
    end else begin
      wr_pos <= wr_pos_n;
      if (wr_frame)     wr_off <= '0;
      else if (wr_byte) wr_off <= wr_off + 1'b1;

      if (ovf) begin
        fill   <= -FILL_W'(1);
        ovf    <= 1'b0;
        rd_pos <= wr_pos_n - REWIND_P;
        rd_off <= '0;
      end else begin
        fill <= fill_step[FILL_W-1:0];
        ovf  <= ovf_hit;
        if (rd_frame) begin
          rd_pos <= rd_pos + 1'b1;
          rd_off <= '0;
        end else if (rd_byte) begin
          rd_off <= rd_off + 1'b1;
        end
      end

      if (!ovf && ovf_hit)       mute_q <= 1'b1;
      else if (!ovf && rd_frame) mute_q <= 1'b0;
    end
  end

  always_comb begin
    fill_sat = fill;
    if (fill > CODE_HI)      fill_sat = CODE_HI;
    else if (fill < CODE_LO) fill_sat = CODE_LO;
  end

  assign wr_addr   = {wr_pos, wr_off};
  assign rd_addr   = {rd_pos, rd_off};
  assign speed_up  = !ovf && (fill <= HINT_LO);
  assign slow_down = !ovf && (fill >= HINT_HI);
  assign buf_over  = ovf;
  assign mute      = mute_q;
  assign fill_code = ovf ? 3'b100 : fill_sat[2:0];

  // R5
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);

  // R5
  ovf_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (fill == -FILL_W'(1)));

  // R5
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill <= FILL_W'(LIMIT + 1)) && (fill >= -FILL_W'(LIMIT + 1)));

  // R4
  hint_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(speed_up && slow_down));

  // R4
  hint_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_over |-> (!speed_up && !slow_down));

  // R6
  mute_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_over) |-> mute);

  // R8
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pos - rd_pos) == (HALF_P + POS_W'(fill)));
endmodule

// File: tb/tb_jitbuf_addr_ctl.sv
module tb_jitbuf_addr_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_frame = 1'b0, wr_byte = 1'b0, rd_frame = 1'b0, rd_byte = 1'b0;
  logic [10:0] wr_addr, rd_addr;
  logic speed_up, slow_down, buf_over, mute;
  logic [2:0] fill_code;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  jitbuf_addr_ctl dut (
    .clk(clk), .rst_n(rst_n),
    .wr_frame(wr_frame), .wr_byte(wr_byte),
    .rd_frame(rd_frame), .rd_byte(rd_byte),
    .wr_addr(wr_addr), .rd_addr(rd_addr),
    .speed_up(speed_up), .slow_down(slow_down),
    .buf_over(buf_over), .mute(mute), .fill_code(fill_code)
  );

  // {wr_frame, rd_frame, fill_code[2:0], speed_up, slow_down, buf_over, mute}
  localparam logic [8:0] VEC [20] = '{
    9'b1_0_001_0000, 9'b1_0_010_0100, 9'b1_1_010_0100, 9'b1_0_011_0100,
    9'b1_0_011_0100, 9'b1_0_011_0100, 9'b1_0_100_0011, 9'b0_0_111_0001,
    9'b0_1_110_1000, 9'b0_1_101_1000, 9'b0_1_101_1000, 9'b1_0_101_1000,
    9'b0_1_101_1000, 9'b0_1_101_1000, 9'b0_1_100_0011, 9'b0_0_111_0001,
    9'b1_0_000_0001, 9'b0_1_111_0000, 9'b1_0_000_0000, 9'b1_0_001_0000
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic wf, input logic wb, input logic rf, input logic rb);
    @(negedge clk);
    wr_frame = wf; wr_byte = wb; rd_frame = rf; rd_byte = rb;
    @(negedge clk);
    wr_frame = 1'b0; wr_byte = 1'b0; rd_frame = 1'b0; rd_byte = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    check("R1 fill_code", fill_code, 0);
    check("R1 flags", {speed_up, slow_down, buf_over, mute}, 0);
    check("R1 wr_addr", wr_addr, 0);
    check("R1 rd_addr", rd_addr, 1024);

    // R2 R3 R4 R5 R6: vector walk
    for (int i = 0; i < 20; i++) begin
      pulse(VEC[i][8], 1'b0, VEC[i][7], 1'b0);
      check($sformatf("R2/R3 code step %0d", i), fill_code, VEC[i][6:4]);
      check($sformatf("R4 speed_up step %0d", i), speed_up, VEC[i][3]);
      check($sformatf("R4 slow_down step %0d", i), slow_down, VEC[i][2]);
      check($sformatf("R5 buf_over step %0d", i), buf_over, VEC[i][1]);
      check($sformatf("R6 mute step %0d", i), mute, VEC[i][0]);
    end

    // R7 addressing
    do_reset();
    repeat (3) pulse(1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 wr byte count", wr_addr, 3);
    pulse(1'b1, 1'b1, 1'b0, 1'b0);
    check("R7 frame over byte", wr_addr, 32);
    repeat (2) pulse(1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 rd byte count", rd_addr, 1026);
    repeat (33) pulse(1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 rd offset wrap", rd_addr, 1027);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 rd frame advance", rd_addr, 1056);
    check("R2 balanced fill", fill_code, 0);

    // R8 recovery repositioning, R6 mute release
    do_reset();
    repeat (5) pulse(1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 slow_down at +5", slow_down, 1);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 overflow at +6", buf_over, 1);
    check("R3 overflow code", fill_code, 4);
    @(negedge clk);
    check("R5 one-cycle flag", buf_over, 0);
    check("R5 fill -1", fill_code, 7);
    check("R8 rd_addr rewind", rd_addr, 1248);
    check("R8 wr_addr kept", wr_addr, 192);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 write keeps mute", mute, 1);
    check("R8 wr after recovery", wr_addr, 224);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    check("R6 read clears mute", mute, 0);
    check("R8 rd advance", rd_addr, 1280);

    // R1 reset mid-run
    pulse(1'b1, 1'b1, 1'b0, 1'b1);
    do_reset();
    @(negedge clk);
    check("R1 reset code", fill_code, 0);
    check("R1 reset rd_addr", rd_addr, 1024);
    check("R1 reset wr_addr", wr_addr, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule